// File: doc/BRIEF.md
# Line-Synchronized Pixel Clock Divider

This block turns a fast reference clock into a pixel clock for a scanning print engine. A 3-bit ratio code picks one of eight even divide factors from 2 to 256. The divided clock comes from a register and has a 50% duty cycle. A one-cycle pixel enable marks each rising edge, so logic downstream can stay on the fast clock and need not use a derived clock.

The ratio code is sampled only while the beam-detect window input is high. The sampled value is held until a line-sync strobe arrives. On that strobe the divider loads the held ratio and restarts its phase. Every scan line then begins with a known pixel-clock phase, and the pixel rate can change from line to line. Between strobes the output cannot be disturbed. An output-enable gate is registered next to the clock. A pad wrapper uses it to tri-state the pixel clock.

Top module: `pix_line_div`

## Requirements
- R1: The ratio code selects the pixel period in fast-clock cycles as follows: 0 gives 16, 1 gives 32, 2 gives 64, 3 gives 128, 4 gives 256, 5 gives 2, 6 gives 4 and 7 gives 8.
- R2: Within each pixel period, `pix_clk_o` is high for exactly half the period and low for the other half.
- R3: Changes on `ratio_i` while `bd_win_i` is low have no effect on the pixel period.
- R4: A code sampled during the window takes effect only at the next `line_sync_i` strobe. Until then the current period continues unchanged, and a strobe with no window in between applies the last code sampled.
- R5: After a fast-clock edge that samples `line_sync_i` high, `pix_clk_o` and `pix_en_o` are both low. If the strobe is then low, the next edge raises both, which starts the first full period of the new ratio.
- R6: `pix_en_o` is high for exactly one fast-clock cycle, and only in the first cycle of each high phase of `pix_clk_o`.
- R7: `pix_oe_o` follows `oe_i` with a delay of one fast-clock cycle.
- R8: While reset is held, all outputs are low and the ratio is 16. The first edge after reset is released raises `pix_clk_o` and `pix_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 3 | Divide ratio code |
| bd_win_i | input | 1 | Beam-detect window; the ratio code is sampled while this is high |
| line_sync_i | input | 1 | Synchronized line-start strobe; applies the held ratio and restarts the phase |
| oe_i | input | 1 | Output enable request |
| pix_clk_o | output | 1 | Divided pixel clock |
| pix_en_o | output | 1 | One-cycle pulse on each pixel clock rising edge |
| pix_oe_o | output | 1 | Registered output-enable gate for the pixel clock pad |

## Verification
The bench uses the package defaults: a 3-bit code, a base shift of 4 for the five slow codes, and an 8-bit phase counter. These values make every code reachable. At one end is the divide-by-2 case, where each phase lasts one cycle and the enable fires on every other edge. At the other is divide-by-256, where the counter runs its full range. Each line drives the code within the window, then scrambles the code after the window closes. Further cases sample a code without a strobe, and then strobe without a window. These show that the held code is applied only at the line start.

// File: rtl/pld_pkg.sv
package pld_pkg;
  localparam int CODE_W    = 3;
  localparam int HI_BASE   = 4;   // shift for code 0
  localparam int HI_CNT    = 5;   // codes 0..HI_CNT-1 use HI_BASE+code
  localparam int MAX_SHIFT = HI_BASE + HI_CNT - 1;
  localparam int SH_W      = $clog2(MAX_SHIFT + 1);
  localparam int CNT_W     = MAX_SHIFT;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SH_W-1:0]   shift_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  function automatic shift_t code_to_shift(code_t c);
    if (int'(c) < HI_CNT) return shift_t'(HI_BASE + int'(c));
    else                  return shift_t'(int'(c) - HI_CNT + 1);
  endfunction

  function automatic cnt_t shift_last(shift_t s);
    logic [CNT_W:0] full;
    full = (CNT_W+1)'(1) << s;
    return cnt_t'(full - 1'b1);
  endfunction

  function automatic cnt_t shift_half(shift_t s);
    logic [CNT_W:0] full;
    full = (CNT_W+1)'(1) << s;
    return cnt_t'(full >> 1);
  endfunction
endpackage

// File: rtl/pld_ratio_hold.sv
module pld_ratio_hold
  import pld_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  code_t  code_i,
  input  logic   win_i,
  output shift_t lat_shift_o
);
  code_t lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lat_q <= '0;
    else if (win_i) lat_q <= code_i;
  end

  assign lat_shift_o = code_to_shift(lat_q);
endmodule

// File: rtl/pld_phase_gen.sv
module pld_phase_gen
  import pld_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sync_i,
  input  shift_t load_shift_i,
  output logic   clk_o,
  output logic   en_o
);
  localparam shift_t RST_SHIFT = code_to_shift('0);

  shift_t shift_q;
  cnt_t   cnt_q, cnt_nx, last_cur, half_cur;
  logic   clk_q, en_q;

  always_comb begin
    last_cur = shift_last(shift_q);
    half_cur = shift_half(shift_q);
    cnt_nx   = (cnt_q == last_cur) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= RST_SHIFT;
      cnt_q   <= shift_last(RST_SHIFT);
      clk_q   <= 1'b0;
      en_q    <= 1'b0;
    end else if (sync_i) begin
      // park on last slot: next edge opens a full period
      shift_q <= load_shift_i;
      cnt_q   <= shift_last(load_shift_i);
      clk_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      clk_q   <= (cnt_nx < half_cur);
      en_q    <= (cnt_nx == '0);
    end
  end

  assign clk_o = clk_q;
  assign en_o  = en_q;
endmodule

// File: rtl/pix_line_div.sv
module pix_line_div
  import pld_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] ratio_i,
  input  logic              bd_win_i,
  input  logic              line_sync_i,
  input  logic              oe_i,
  output logic              pix_clk_o,
  output logic              pix_en_o,
  output logic              pix_oe_o
);
  shift_t lat_shift;
  logic   oe_q;

  pld_ratio_hold u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .code_i      (ratio_i),
    .win_i       (bd_win_i),
    .lat_shift_o (lat_shift)
  );

  pld_phase_gen u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sync_i       (line_sync_i),
    .load_shift_i (lat_shift),
    .clk_o        (pix_clk_o),
    .en_o         (pix_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= oe_i;
  end

  assign pix_oe_o = oe_q;
endmodule

// File: rtl/pix_line_div_chk.sv
module pix_line_div_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic line_sync_i,
  input logic oe_i,
  input logic pix_clk_o,
  input logic pix_en_o,
  input logic pix_oe_o
);
  assert_en_on_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_o |-> (pix_clk_o && !$past(pix_clk_o)));

  assert_rise_has_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pix_clk_o) |-> pix_en_o);

  assert_sync_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_sync_i |=> (!pix_clk_o && !pix_en_o));

  assert_sync_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_sync_i ##1 !line_sync_i |=> pix_en_o);

  assert_oe_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |=> pix_oe_o);

  assert_oe_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> !pix_oe_o);
endmodule

bind pix_line_div pix_line_div_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_sync_i (line_sync_i),
  .oe_i        (oe_i),
  .pix_clk_o   (pix_clk_o),
  .pix_en_o    (pix_en_o),
  .pix_oe_o    (pix_oe_o)
);

// File: tb/pix_line_div_test.sv
module pix_line_div_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ratio = '0;
  logic       win = 1'b0, sync = 1'b0, oe = 1'b0;
  logic       pix_clk, pix_en, pix_oe;

  int n_run = 0, n_fail = 0, cyc = 0;
  int exp_q[$];
  string tag_q[$];
  bit meas_valid = 0, prev_clk = 0, done = 0;
  int last_en = 0, hi_cnt = 0, hi_last = 0;

  pix_line_div uut (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio), .bd_win_i(win),
    .line_sync_i(sync), .oe_i(oe),
    .pix_clk_o(pix_clk), .pix_en_o(pix_en), .pix_oe_o(pix_oe)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // R1 table
  function automatic int div_of(input logic [2:0] c);
    case (c)
      3'd0: return 16;  3'd1: return 32;  3'd2: return 64;  3'd3: return 128;
      3'd4: return 256; 3'd5: return 2;   3'd6: return 4;   default: return 8;
    endcase
  endfunction

  task automatic push(input int n, input int per, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(per);
      tag_q.push_back(tag);
    end
  endtask

  // monitor: period and high width between enable pulses
  always @(negedge clk) if (rst_n) begin
    if (pix_clk) hi_cnt++;
    else if (prev_clk) begin hi_last = hi_cnt; hi_cnt = 0; end
    if (pix_en) begin
      if (meas_valid && exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cyc - last_en == e, {t, " R1 period"}, cyc - last_en, e);
        check(hi_last == e / 2, {t, " R2 high width"}, hi_last, e / 2);
      end
      last_en = cyc;
      meas_valid = 1;
    end
    prev_clk = pix_clk;
  end

  task automatic new_line(input logic [2:0] code, input bit use_win, input int per, input string tag);
    @(posedge clk); #1;
    if (use_win) begin ratio = code; win = 1'b1; end
    @(posedge clk); #1 sync = 1'b1;
    @(posedge clk); #1;
    sync = 1'b0; win = 1'b0; ratio = ~code;  // R3 disturbance outside window
    meas_valid = 0;
    check(!pix_clk && !pix_en, {tag, " R5 low after sync"}, {pix_clk, pix_en}, 0);
    push(3, per, tag);
    @(posedge clk); #1;
    check(pix_clk && pix_en, {tag, " R5 first rise"}, {pix_clk, pix_en}, 3);
    @(posedge clk); #1;
    check(!pix_en, {tag, " R6 one-cycle enable"}, pix_en, 0);
    wait (exp_q.size() == 0);
  endtask

  initial begin
    #1;
    check(!pix_clk && !pix_en && !pix_oe, "R8 reset outputs", {pix_clk, pix_en, pix_oe}, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check(pix_clk && pix_en, "R8 first rise after reset", {pix_clk, pix_en}, 3);
    push(2, 16, "R8 default");
    wait (exp_q.size() == 0);

    for (int c = 0; c < 8; c++)
      new_line(3'(c), 1'b1, div_of(3'(c)), $sformatf("R1 code %0d", c));

    // R4: sample code 5 without strobe; ÷8 keeps running
    new_line(3'd7, 1'b1, 8, "R4 base");
    @(posedge clk); #1 ratio = 3'd5; win = 1'b1;
    @(posedge clk); #1 win = 1'b0; ratio = 3'd4;
    push(3, 8, "R4 held no sync");
    wait (exp_q.size() == 0);
    // strobe without window applies the held code (÷2), not ratio_i
    new_line(3'd0, 1'b0, 2, "R4 sync applies held");
    push(3, 2, "R3 ignored outside window");
    wait (exp_q.size() == 0);

    // R7
    @(posedge clk); #1 oe = 1'b1;
    check(!pix_oe, "R7 oe delay", pix_oe, 0);
    @(posedge clk); #1;
    check(pix_oe, "R7 oe on", pix_oe, 1);
    oe = 1'b0;
    @(posedge clk); #1;
    check(!pix_oe, "R7 oe off", pix_oe, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule